// File: doc/BRIEF.md
# Dual-Bank Stop-Triggered Sample Capture Buffer

The block records a continuous stream of 16-bit samples from eight ADC channels into per-channel circular storage. Every channel owns two banks of 256 words. While acquisition runs, one bank per channel is overwritten in a ring. A trigger pulse on `stop` freezes that bank and moves recording at once to the other bank, so sampling never pauses for the trigger.

After a trigger, a sequencer drains a short window from the frozen bank of every channel into a shared 1024-word output FIFO, which a local-bus reader empties. The window is the four samples that end at the last address written at or before the trigger. Each channel's group of four samples is led by the current event number, so one event fills 40 FIFO words. The sequencer waits while the FIFO is full and goes on without losing anything. A trigger that arrives before the frozen bank has been fully drained is refused.

Top module: `pp_capture`

## Requirements
- R1: While `run` is 1, each clock writes `adc_bus` (channel n at bits n*16+15..n*16) into the recording bank at a shared write address, and the address then steps by one modulo 256. While `run` is 0, nothing is written and the address holds.
- R2: A `stop` sampled while `busy` is 0 is accepted. The sample of that cycle still goes into the bank being recorded, which then freezes. Recording continues from the next cycle in the other bank with no sample skipped.
- R3: For an accepted stop, the window of each channel is the four frozen-bank samples at addresses L-3, L-2, L-1 and L, taken modulo 256. L is the write address of the stop cycle when `run` is 1, and that address minus one when `run` is 0.
- R4: An event enters the FIFO as 40 words: channel 0 first and channel 7 last. Each channel contributes its event number, then its four window samples, oldest first.
- R5: The event number is a 16-bit count of previously accepted stops. It is 0 for the first event, rises by one per accepted stop and wraps from 65535 to 0.
- R6: A `stop` sampled while `busy` is 1 is ignored: it adds no event, changes no bank and leaves the event number alone.
- R7: `busy` goes to 1 on the edge that accepts a stop. When the FIFO never blocks, it returns to 0 exactly 41 clock cycles later, on the edge that writes the event's last word.
- R8: The FIFO holds 1024 words and `fifo_full` is 1 exactly when it holds 1024. The readout stalls while no room is left, then resumes with no word lost or repeated, and `busy` stays 1 for the whole stall.
- R9: `fifo_dout` shows the oldest word whenever `fifo_empty` is 0. `fifo_rd` removes that word on the clock edge. A `fifo_rd` while `fifo_empty` is 1 has no effect.
- R10: After reset, `fifo_empty` is 1 and both `fifo_full` and `busy` are 0. The write address, the recording bank and the event number all start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Acquisition enable; writes the current samples |
| adc_bus | input | 128 | Eight 16-bit samples, channel n in bits n*16+15..n*16 |
| stop | input | 1 | Trigger pulse that freezes the recording bank |
| fifo_rd | input | 1 | Pop request from the local-bus reader |
| fifo_dout | output | 16 | Oldest FIFO word (show-ahead) |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds 1024 words |
| busy | output | 1 | A frozen bank is still being drained; stops are refused |

## Verification
A bad write address or bank select stays hidden until the next accepted stop. It then shows within one event (40 words after the header) as window samples that do not match the stream the bench drove. A wrong event counter shows in the very first header word of the next event. A mistake in the room check or the stall logic appears as a missing or repeated word in the drained stream, or as `busy` not holding for 41 cycles. The bench fills the FIFO on purpose and wraps the window across address zero, so these faults surface within a few hundred cycles.

// File: rtl/pp_pkg.sv
package pp_pkg;

  // Readout sequencer phases
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_FLUSH = 2'd2
  } seq_state_e;

  // Address of window slot `slot` (1..nslot, oldest first) ending at `last`.
  // The caller truncates to the ring width, which gives the modulo wrap.
  function automatic int win_addr(input int last, input int slot, input int nslot);
    return last - nslot + slot;
  endfunction

  // Free-space test for the output FIFO, counting a word already in flight.
  function automatic bit has_room(input int count, input int inflight, input int depth);
    return (count + inflight) < depth;
  endfunction

endpackage

// File: rtl/pp_bank_ram.sv
// Two-bank ring storage for one channel: bank select is the address MSB.
module pp_bank_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW:0]   waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW:0]   raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 2 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_wr_ctrl.sv
// Write address, recording bank, trigger acceptance and event numbering.
module pp_wr_ctrl #(
  parameter int AW = 8,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          stop,
  input  logic          busy,
  output logic          we,
  output logic [AW:0]   waddr,
  output logic          wbank,
  output logic [AW-1:0] wptr,
  output logic          stop_acc,
  output logic [AW-1:0] last_addr,
  output logic [EW-1:0] evt_cnt
);
  assign stop_acc  = stop && !busy;
  assign we        = run;
  assign waddr     = {wbank, wptr};
  assign last_addr = run ? wptr : wptr - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      wbank   <= 1'b0;
      evt_cnt <= '0;
    end else begin
      if (run) wptr <= wptr + 1'b1;
      if (stop_acc) begin
        wbank   <= ~wbank;
        evt_cnt <= evt_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pp_rd_seq.sv
// Drains the frozen bank: per channel a header word then SLOTS samples.
module pp_rd_seq
  import pp_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int DW         = 16,
  parameter int AW         = 8,
  parameter int SLOTS      = 4,
  parameter int FIFO_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_acc,
  input  logic              frz_bank,
  input  logic [AW-1:0]     frz_last,
  input  logic [DW-1:0]     frz_evt,
  input  logic [$clog2(FIFO_DEPTH):0] fifo_cnt,
  input  logic [NCH*DW-1:0] ram_q,
  output logic [AW:0]       raddr,
  output logic              busy,
  output logic              push,
  output logic [DW-1:0]     push_data
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SW = $clog2(SLOTS + 1);

  seq_state_e    state;
  logic [CW-1:0] ch;
  logic [SW-1:0] sub;
  logic          rbank;
  logic [AW-1:0] rlast;
  logic [DW-1:0] revt;

  logic          s1_valid, s1_hdr, s1_last;
  logic [CW-1:0] s1_ch;

  logic          room, issue, last_word, ch_done;
  logic [AW-1:0] slot_addr;

  assign room      = has_room(int'(fifo_cnt), int'(s1_valid), FIFO_DEPTH);
  assign issue     = (state == SQ_ISSUE) && room;
  assign ch_done   = (sub == SW'(SLOTS));
  assign last_word = ch_done && (ch == CW'(NCH - 1));
  assign slot_addr = AW'(win_addr(int'(rlast), int'(sub), SLOTS));
  assign raddr     = {rbank, slot_addr};
  assign busy      = (state != SQ_IDLE);

  assign push      = s1_valid;
  assign push_data = s1_hdr ? revt : ram_q[s1_ch*DW +: DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      ch       <= '0;
      sub      <= '0;
      rbank    <= 1'b0;
      rlast    <= '0;
      revt     <= '0;
      s1_valid <= 1'b0;
      s1_hdr   <= 1'b0;
      s1_last  <= 1'b0;
      s1_ch    <= '0;
    end else begin
      s1_valid <= issue;
      if (issue) begin
        s1_hdr  <= (sub == '0);
        s1_ch   <= ch;
        s1_last <= last_word;
      end
      unique case (state)
        SQ_IDLE: begin
          if (stop_acc) begin
            state <= SQ_ISSUE;
            ch    <= '0;
            sub   <= '0;
            rbank <= frz_bank;
            rlast <= frz_last;
            revt  <= frz_evt;
          end
        end
        SQ_ISSUE: begin
          if (issue) begin
            if (ch_done) begin
              sub <= '0;
              ch  <= ch + 1'b1;
            end else begin
              sub <= sub + 1'b1;
            end
            if (last_word) state <= SQ_FLUSH;
          end
        end
        SQ_FLUSH: begin
          if (s1_valid && s1_last) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_out_fifo.sv
// Show-ahead synchronous FIFO feeding the local-bus reader.
module pp_out_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [DW-1:0]           din,
  input  logic                    pop,
  output logic [DW-1:0]           dout,
  output logic                    empty,
  output logic                    full,
  output logic [$clog2(DEPTH):0]  count
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/pp_capture.sv
// Top: eight channels of dual-bank ring capture, drained into one FIFO.
module pp_capture #(
  parameter int NCH        = 8,
  parameter int DW         = 16,
  parameter int DEPTH      = 256,
  parameter int SLOTS      = 4,
  parameter int FIFO_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [NCH*DW-1:0] adc_bus,
  input  logic              stop,
  input  logic              fifo_rd,
  output logic [DW-1:0]     fifo_dout,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              busy
);
  localparam int AW  = $clog2(DEPTH);
  localparam int FAW = $clog2(FIFO_DEPTH);

  // Named internal events, also observed by the bound checker
  logic          we, wbank, stop_acc, fifo_push, fifo_pop;
  logic [AW:0]   waddr, raddr;
  logic [AW-1:0] wptr, last_addr;
  logic [DW-1:0] evt_cnt, push_data;
  logic [FAW:0]  fifo_cnt;
  logic [NCH*DW-1:0] ram_q;

  assign fifo_pop = fifo_rd && !fifo_empty;

  pp_wr_ctrl #(.AW(AW), .EW(DW)) u_wr (
    .clk, .rst_n, .run, .stop, .busy,
    .we, .waddr, .wbank, .wptr, .stop_acc, .last_addr, .evt_cnt
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pp_bank_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (adc_bus[g*DW +: DW]),
      .raddr (raddr),
      .rdata (ram_q[g*DW +: DW])
    );
  end

  pp_rd_seq #(
    .NCH(NCH), .DW(DW), .AW(AW), .SLOTS(SLOTS), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_seq (
    .clk, .rst_n, .stop_acc,
    .frz_bank (wbank),
    .frz_last (last_addr),
    .frz_evt  (evt_cnt),
    .fifo_cnt,
    .ram_q,
    .raddr,
    .busy,
    .push      (fifo_push),
    .push_data
  );

  pp_out_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n,
    .push  (fifo_push),
    .din   (push_data),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full),
    .count (fifo_cnt)
  );
endmodule

// File: rtl/pp_capture_chk.sv
module pp_capture_chk #(
  parameter int AW = 8,
  parameter int EW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          stop,
  input logic          busy,
  input logic          stop_acc,
  input logic          wbank,
  input logic [AW-1:0] wptr,
  input logic [EW-1:0] evt_cnt,
  input logic          fifo_push,
  input logic          fifo_pop,
  input logic          fifo_full,
  input logic          fifo_empty
);
  a_r1_wptr_adv: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> wptr == $past(wptr) + 1'b1);

  a_r1_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> wptr == $past(wptr));

  a_r2_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
    stop_acc |=> wbank != $past(wbank));

  a_r5_evt_step: assert property (@(posedge clk) disable iff (!rst_n)
    stop_acc |=> evt_cnt == $past(evt_cnt) + 1'b1);

  a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && busy) |=> (wbank == $past(wbank)) && (evt_cnt == $past(evt_cnt)));

  a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    stop_acc |=> busy);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !(fifo_push && !fifo_pop));

  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !fifo_push) |=> fifo_empty);
endmodule

bind pp_capture pp_capture_chk #(.AW($clog2(DEPTH)), .EW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .stop       (stop),
  .busy       (busy),
  .stop_acc   (stop_acc),
  .wbank      (wbank),
  .wptr       (wptr),
  .evt_cnt    (evt_cnt),
  .fifo_push  (fifo_push),
  .fifo_pop   (fifo_pop),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty)
);

// File: tb/sim_pp_capture.sv
module sim_pp_capture;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0;
  logic [127:0] adc_bus = '0;
  logic         stop = 1'b0;
  logic         fifo_rd = 1'b0;
  logic [15:0]  fifo_dout;
  logic         fifo_empty, fifo_full, busy;

  int ntests = 0;
  int nfail  = 0;

  // Bench-side model of the storage and counters
  logic [15:0] bmem [2][8][256];
  int          wp  = 0;
  int          wb  = 0;
  int          evt = 0;
  logic [15:0] expq [$];

  always #(CLK_P/2) clk = ~clk;

  pp_capture u0 (
    .clk, .rst_n, .run, .adc_bus, .stop, .fifo_rd,
    .fifo_dout, .fifo_empty, .fifo_full, .busy
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ring(input int a);
    return (a + 256) % 256;
  endfunction

  // One cycle: drive at the falling edge, update the model, advance.
  task automatic step(input bit r, input bit s, input bit rd);
    logic [15:0] smp [8];
    logic [15:0] e;
    bit acc;
    int last;
    for (int c = 0; c < 8; c++) begin
      smp[c] = 16'($urandom);
      adc_bus[c*16 +: 16] = smp[c];
    end
    run = r; stop = s; fifo_rd = rd;
    if (rd && !fifo_empty) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected word", int'(fifo_dout), -1);
      end else begin
        e = expq.pop_front();
        chk(fifo_dout === e, "R2/R3/R4/R5 stream word", int'(fifo_dout), int'(e));
      end
    end
    acc = s && !busy;
    if (r) for (int c = 0; c < 8; c++) bmem[wb][c][wp] = smp[c];
    if (acc) begin
      last = r ? wp : ring(wp - 1);
      for (int c = 0; c < 8; c++) begin
        expq.push_back(16'(evt));
        for (int k = 0; k < 4; k++) expq.push_back(bmem[wb][c][ring(last - 3 + k)]);
      end
      evt++;
      wb ^= 1;
    end
    if (r) wp = ring(wp + 1);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((!fifo_empty || busy || expq.size() != 0) && n < 4000) begin
      step(1'b1, 1'b0, 1'b1);
      n++;
    end
    chk(fifo_empty && !busy && expq.size() == 0, req, expq.size(), 0);
  endtask

  initial begin
    #(CLK_P * 190000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    int cnt;
    bit ok;
    void'($urandom(32'd20031));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(fifo_empty === 1'b1, "R10 empty after reset", int'(fifo_empty), 1);
    chk(fifo_full === 1'b0, "R10 not full after reset", int'(fifo_full), 0);
    chk(busy === 1'b0, "R10 not busy after reset", int'(busy), 0);

    // Fill bank 0 completely
    repeat (300) step(1'b1, 1'b0, 1'b1);

    // R7: busy length with a free FIFO; header 0 checked by the stream (R5)
    step(1'b1, 1'b1, 1'b1);
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      step(1'b1, 1'b0, 1'b1);
    end
    chk(cnt == 41, "R7 busy cycles", cnt, 41);
    drain("R2 first event drained");
    repeat (300) step(1'b1, 1'b0, 1'b1);

    // R6: stop during readout is refused
    step(1'b1, 1'b1, 1'b1);
    repeat (5) step(1'b1, 1'b0, 1'b1);
    chk(busy === 1'b1, "R6 busy at second stop", int'(busy), 1);
    step(1'b1, 1'b1, 1'b1);
    drain("R6 no extra event");

    // R1/R3: stop while run is low takes the last written address
    repeat (3) step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1);
    repeat (3) step(1'b0, 1'b0, 1'b1);
    drain("R1 run-low window");

    // R3: window wrapping across address 0
    while (wp != 1) step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    drain("R3 wrapped window");

    // R8: fill the FIFO with no reader, then release
    cnt = 0;
    while (!fifo_full && cnt < 3000) begin
      step(1'b1, 1'b1, 1'b0);
      cnt++;
    end
    chk(fifo_full === 1'b1, "R8 full reached", int'(fifo_full), 1);
    ok = 1'b1;
    repeat (20) begin
      ok &= (busy === 1'b1) && (fifo_full === 1'b1);
      step(1'b1, 1'b1, 1'b0);
    end
    chk(ok, "R8 stall holds busy", int'(ok), 1);
    drain("R8 stream after stall");

    // R9: reads on an empty FIFO change nothing
    repeat (5) step(1'b1, 1'b0, 1'b1);
    chk(fifo_empty === 1'b1 && expq.size() == 0, "R9 empty read ignored",
        int'(fifo_empty), 1);

    // Constrained random traffic with slow and fast reader phases
    for (int i = 0; i < 20000; i++) begin
      bit slow = ((i / 1500) % 2) == 1;
      step(($urandom % 10) != 0, ($urandom % 30) == 0,
           slow ? (($urandom % 10) == 0) : (($urandom % 10) < 7));
    end
    drain("R4 random traffic drained");
    chk(evt > 30, "R5 events accepted", evt, 31);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule